// File: doc/BRIEF.md
# PCI Function Power-State Controller

This block holds the device power state of one PCI bridge function and presents it to software through a small power-management capability block in configuration space. Internally it tracks seven states: an unconfigured D0, an active D0, D1, D2, and three D3 flavours (hot, cold and unpowered). Software sees only a two-bit state code in the control/status word. Hardware events move the function between states without software: the command enable bits, a global reset, the release of a bus reset, and the main and auxiliary power indications.

Configuration access uses a dword address, byte enables and write data. Reads are combinational on the addressed dword. The block also produces two gating outputs. One permits interrupt generation and the other permits PME signalling, so that a function that has not been configured stays silent.

Top module: `pci_pm_ctrl`

## Requirements
- R1: After the synchronous reset `rst_n` is low at a clock edge, `pm_state` is 0 and PME enable is 0. The `pm_state` encoding is: 0 unconfigured D0, 1 active D0, 2 D1, 3 D2, 4 D3hot, 5 D3cold, 6 D3off.
- R2: The state leaves 0 only for 1, and only at an edge where `cmd_io_en` and `cmd_mem_en` are both 1. Either bit alone leaves the state at 0. Power loss and global reset are the exceptions.
- R3: `irq_allow` is 1 only in state 1. `pme_allow` is 1 when PME enable is set and the state is one of 1 to 5, and is 0 in states 0 and 6.
- R4: Bits 1:0 of control dword 0x29 (byte offset A4h) read 00 in states 0 and 1, 01 in D1, 10 in D2, and 11 in all three D3 states.
- R5: A write to dword 0x29 with `cfg_be[0]` set requests the code in `cfg_wdata[1:0]`. The legal transitions are: active D0 to D1, D2 or D3hot; D1 to D0, D2 or D3hot; D2 to D0 or D3hot. A D0 request from D1 or D2 goes to state 1. Any other request, and any request in states 0, 5 or 6, leaves the state unchanged.
- R6: Writing code 00 in D3hot moves to state 0. The function then needs both enable bits again before it reaches state 1.
- R7: In D3hot, an edge with `main_pwr` 0 and `aux_pwr` 1 moves to D3cold. PME enable is kept.
- R8: In D3cold, the edge after `bus_rst` falls from 1 to 0 moves to state 0.
- R9: An edge with both `main_pwr` and `aux_pwr` at 0 moves any state to D3off. D3off is held, even after power returns, until a global reset.
- R10: An edge with `glob_rst` at 1 moves any state to 0 and clears PME enable. This takes priority over power loss and over configuration writes in the same cycle.
- R11: Dword 0x28 (byte offset A0h) reads {PM_CAPS, NEXT_PTR, 8'h01} (defaults 16'h0602 and 8'h00) and ignores writes. Dword 0x01 reads bit 20 (status bit 4) as 1, bits 1:0 as {`cmd_mem_en`, `cmd_io_en`}, and all other bits as 0.
- R12: PME enable is bit 8 of dword 0x29. It is written only when `cfg_be[1]` is set. Without `cfg_be[0]`, a write does not touch the state. Unmapped dwords read 0.
- R13: When a power event (R7, R9) or a global reset falls in the same cycle as a state write, the hardware event decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_rst | input | 1 | Global reset, active high, sampled at the edge |
| bus_rst | input | 1 | Bus reset, active high; its release wakes D3cold |
| main_pwr | input | 1 | Main power present |
| aux_pwr | input | 1 | Auxiliary power present |
| cmd_io_en | input | 1 | I/O enable bit of the command register |
| cmd_mem_en | input | 1 | Memory enable bit of the command register |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| pm_state | output | 3 | Internal power state (R1 encoding) |
| irq_allow | output | 1 | Interrupt generation permitted |
| pme_allow | output | 1 | PME signalling permitted |

## Verification
A software write to the state field can land in the same cycle as a main-power drop, and so can a global reset. The bench provokes both collisions. It issues a D0 write from D3hot while main power falls, and a write to the control dword while global reset is high. The reference model's priority order judges the result: the next state must follow the hardware event, and PME enable must be cleared. The bench also lands a write in the same cycle that the enable bits complete the exit from unconfigured D0.

// File: rtl/pm_pkg.sv
// Package: shared state type and the mapping to the software-visible code.
// Assumes a three-bit encoding, which the R1 encoding fixes.
package pm_pkg;

    typedef enum logic [2:0] {
        PM_D0U   = 3'd0,
        PM_D0A   = 3'd1,
        PM_D1    = 3'd2,
        PM_D2    = 3'd3,
        PM_D3H   = 3'd4,
        PM_D3C   = 3'd5,
        PM_D3OFF = 3'd6
    } pm_state_e;

    // Two-bit code that software reads for an internal state
    function automatic logic [1:0] pm_vis_code(input pm_state_e s);
        case (s)
            PM_D0U, PM_D0A: pm_vis_code = 2'b00;
            PM_D1:          pm_vis_code = 2'b01;
            PM_D2:          pm_vis_code = 2'b10;
            default:        pm_vis_code = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/pm_state_fsm.sv
// Module: pm_state_fsm
// Holds the seven-state power register. Hardware events outrank software
// requests. Assumes all inputs are synchronous to clk. A bus-reset release
// is found by comparing the input with its value at the previous edge.
module pm_state_fsm
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      glob_rst,
    input  logic      bus_rst,
    input  logic      main_pwr,
    input  logic      aux_pwr,
    input  logic      io_en,
    input  logic      mem_en,
    input  logic      sw_req,
    input  logic [1:0] sw_code,
    output pm_state_e state_q
);

    logic      bus_rst_q;
    logic      bus_release;
    logic      pwr_gone;
    pm_state_e sw_target;
    pm_state_e state_d;

    assign bus_release = bus_rst_q & ~bus_rst;
    assign pwr_gone    = ~main_pwr & ~aux_pwr;

    // Resolve the software request against the legal transition set
    always_comb begin
        sw_target = state_q;
        case (state_q)
            PM_D0A: begin
                if (sw_code == 2'b01)      sw_target = PM_D1;
                else if (sw_code == 2'b10) sw_target = PM_D2;
                else if (sw_code == 2'b11) sw_target = PM_D3H;
            end
            PM_D1: begin
                if (sw_code == 2'b00)      sw_target = PM_D0A;
                else if (sw_code == 2'b10) sw_target = PM_D2;
                else if (sw_code == 2'b11) sw_target = PM_D3H;
            end
            PM_D2: begin
                if (sw_code == 2'b00)      sw_target = PM_D0A;
                else if (sw_code == 2'b11) sw_target = PM_D3H;
            end
            PM_D3H: begin
                if (sw_code == 2'b00)      sw_target = PM_D0U;
            end
            default: sw_target = state_q;
        endcase
    end

    // Next state, highest priority first
    always_comb begin
        state_d = state_q;
        if (glob_rst) begin
            state_d = PM_D0U;
        end else if (pwr_gone) begin
            state_d = PM_D3OFF;
        end else begin
            case (state_q)
                PM_D3OFF: state_d = PM_D3OFF;
                PM_D3C:   state_d = bus_release ? PM_D0U : PM_D3C;
                PM_D0U:   state_d = (io_en && mem_en) ? PM_D0A : PM_D0U;
                PM_D3H: begin
                    if (!main_pwr)   state_d = PM_D3C;
                    else if (sw_req) state_d = sw_target;
                end
                default: begin
                    if (sw_req) state_d = sw_target;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_D0U;
        else        state_q <= state_d;
    end

    // Previous bus reset level, used for release detection
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rst_q <= 1'b0;
        else        bus_rst_q <= bus_rst;
    end

endmodule

// File: rtl/pm_cfg_regs.sv
// Module: pm_cfg_regs
// Decodes configuration accesses: the status dword, the capability header
// and the control/status word. Holds the PME enable bit. Assumes one dword
// per address and byte enables that apply to writes only.
module pm_cfg_regs
    import pm_pkg::*;
#(
    parameter int                 ADDR_W   = 6,
    parameter int                 DATA_W   = 32,
    parameter logic [ADDR_W-1:0]  STS_DW   = 'h01,
    parameter logic [ADDR_W-1:0]  CAP_DW   = 'h28,
    parameter logic [ADDR_W-1:0]  CTL_DW   = 'h29,
    parameter logic [7:0]         NEXT_PTR = 8'h00,
    parameter logic [15:0]        PM_CAPS  = 16'h0602
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              io_en,
    input  logic              mem_en,
    input  pm_state_e         state,
    output logic              sw_req,
    output logic [1:0]        sw_code,
    output logic              pme_en,
    output logic [DATA_W-1:0] cfg_rdata
);

    localparam logic [7:0] CAP_ID      = 8'h01;
    localparam int         CAPLIST_BIT = 20;
    localparam int         PME_EN_BIT  = 8;

    logic ctl_wr;
    logic pme_en_q;
    logic unused_cfg;

    assign ctl_wr  = cfg_wr && (cfg_addr == CTL_DW);
    assign sw_req  = ctl_wr && cfg_be[0];
    assign sw_code = cfg_wdata[1:0];
    assign pme_en  = pme_en_q;
    assign unused_cfg = ^{cfg_wdata[DATA_W-1:PME_EN_BIT+1],
                          cfg_wdata[PME_EN_BIT-1:2], cfg_be[DATA_W/8-1:2]};

    // PME enable storage, cleared by both resets
    always_ff @(posedge clk) begin
        if (!rst_n)                  pme_en_q <= 1'b0;
        else if (glob_rst)           pme_en_q <= 1'b0;
        else if (ctl_wr && cfg_be[1]) pme_en_q <= cfg_wdata[PME_EN_BIT];
    end

    // Read multiplexer for the addressed dword
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            STS_DW: begin
                cfg_rdata[CAPLIST_BIT] = 1'b1;
                cfg_rdata[1:0]         = {mem_en, io_en};
            end
            CAP_DW: cfg_rdata = {{(DATA_W-32){1'b0}}, PM_CAPS, NEXT_PTR, CAP_ID};
            CTL_DW: begin
                cfg_rdata[PME_EN_BIT] = pme_en_q;
                cfg_rdata[1:0]        = pm_vis_code(state);
            end
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pm_gate.sv
// Module: pm_gate
// Derives the interrupt and PME permission outputs from the state and the
// PME enable bit. Purely combinational.
module pm_gate
    import pm_pkg::*;
(
    input  pm_state_e state,
    input  logic      pme_en,
    output logic      irq_allow,
    output logic      pme_allow
);

    // Interrupts only when configured and fully on; PME wherever powered
    always_comb begin
        irq_allow = (state == PM_D0A);
        pme_allow = pme_en && (state != PM_D0U) && (state != PM_D3OFF);
    end

endmodule

// File: rtl/pci_pm_ctrl.sv
// Module: pci_pm_ctrl (top)
// Power-state controller for one PCI function: state machine, config
// register block and output gating. Assumes a single clock domain with all
// resets and power indications already synchronised.
module pci_pm_ctrl
    import pm_pkg::*;
#(
    parameter int                 ADDR_W   = 6,
    parameter int                 DATA_W   = 32,
    parameter logic [ADDR_W-1:0]  STS_DW   = 'h01,
    parameter logic [ADDR_W-1:0]  CAP_DW   = 'h28,
    parameter logic [ADDR_W-1:0]  CTL_DW   = 'h29,
    parameter logic [7:0]         NEXT_PTR = 8'h00,
    parameter logic [15:0]        PM_CAPS  = 16'h0602
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  glob_rst,
    input  logic                  bus_rst,
    input  logic                  main_pwr,
    input  logic                  aux_pwr,
    input  logic                  cmd_io_en,
    input  logic                  cmd_mem_en,
    input  logic                  cfg_wr,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W/8-1:0]   cfg_be,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    output logic [2:0]            pm_state,
    output logic                  irq_allow,
    output logic                  pme_allow
);

    pm_state_e  state;
    logic       sw_req;
    logic [1:0] sw_code;
    logic       pme_en;

    pm_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .glob_rst (glob_rst),
        .bus_rst  (bus_rst),
        .main_pwr (main_pwr),
        .aux_pwr  (aux_pwr),
        .io_en    (cmd_io_en),
        .mem_en   (cmd_mem_en),
        .sw_req   (sw_req),
        .sw_code  (sw_code),
        .state_q  (state)
    );

    pm_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STS_DW   (STS_DW),
        .CAP_DW   (CAP_DW),
        .CTL_DW   (CTL_DW),
        .NEXT_PTR (NEXT_PTR),
        .PM_CAPS  (PM_CAPS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .glob_rst  (glob_rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .io_en     (cmd_io_en),
        .mem_en    (cmd_mem_en),
        .state     (state),
        .sw_req    (sw_req),
        .sw_code   (sw_code),
        .pme_en    (pme_en),
        .cfg_rdata (cfg_rdata)
    );

    pm_gate u_gate (
        .state     (state),
        .pme_en    (pme_en),
        .irq_allow (irq_allow),
        .pme_allow (pme_allow)
    );

    assign pm_state = state;

endmodule

// File: rtl/pci_pm_ctrl_chk.sv
// Module: pci_pm_ctrl_chk
// Temporal checks on the top-level ports, bound into pci_pm_ctrl.
module pci_pm_ctrl_chk #(
    parameter int                ADDR_W = 6,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTL_DW = 'h29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glob_rst,
    input logic              main_pwr,
    input logic              aux_pwr,
    input logic              cmd_io_en,
    input logic              cmd_mem_en,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [2:0]        pm_state,
    input logic              irq_allow,
    input logic              pme_allow
);

    // R10
    glob_rst_to_d0u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |=> (pm_state == 3'd0));

    // R2
    d0u_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd0 && !(cmd_io_en && cmd_mem_en))
        |=> (pm_state == 3'd0 || pm_state == 3'd6));

    // R3
    d0u_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd0) |-> (!irq_allow && !pme_allow));

    // R9
    d3off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd6 && !glob_rst) |=> (pm_state == 3'd6));

    // R7
    d3cold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd4 && !main_pwr && aux_pwr && !glob_rst)
        |=> (pm_state == 3'd5));

    // R4
    d1_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == CTL_DW && pm_state == 3'd2) |-> (cfg_rdata[1:0] == 2'b01));

endmodule

bind pci_pm_ctrl pci_pm_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_DW (CTL_DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_rst   (glob_rst),
    .main_pwr   (main_pwr),
    .aux_pwr    (aux_pwr),
    .cmd_io_en  (cmd_io_en),
    .cmd_mem_en (cmd_mem_en),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .pm_state   (pm_state),
    .irq_allow  (irq_allow),
    .pme_allow  (pme_allow)
);

// File: tb/pci_pm_ctrl_bench.sv
// Bench: behavioural reference model stepped on every clock and compared
// at the falling edge against all outputs.
module pci_pm_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n, glob_rst, bus_rst, main_pwr, aux_pwr;
    logic        cmd_io_en, cmd_mem_en, cfg_wr;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [2:0]  pm_state;
    logic        irq_allow, pme_allow;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // model state
    int m_st = 0;
    bit m_pme = 0;
    bit m_bus_prev = 0;

    always #10 clk = ~clk;

    pci_pm_ctrl u_pci_pm_ctrl (
        .clk(clk), .rst_n(rst_n), .glob_rst(glob_rst), .bus_rst(bus_rst),
        .main_pwr(main_pwr), .aux_pwr(aux_pwr), .cmd_io_en(cmd_io_en),
        .cmd_mem_en(cmd_mem_en), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pm_state(pm_state), .irq_allow(irq_allow), .pme_allow(pme_allow)
    );

    function automatic int sw_next(int cur, int code);
        int allowed[4];
        allowed = '{-1, -1, -1, -1};
        if (cur == 1) allowed = '{-1, 2, 3, 4};
        if (cur == 2) allowed = '{1, -1, 3, 4};
        if (cur == 3) allowed = '{1, -1, -1, 4};
        if (cur == 4) allowed = '{0, -1, -1, -1};
        return (allowed[code] < 0) ? cur : allowed[code];
    endfunction

    task automatic model_step();
        int nx;
        bit ctl;
        ctl = cfg_wr && (cfg_addr == 6'h29);
        nx = m_st;
        if (!rst_n) begin
            m_st = 0; m_pme = 0; m_bus_prev = 0;
            return;
        end
        if (glob_rst) nx = 0;
        else if (!main_pwr && !aux_pwr) nx = 6;
        else if (m_st == 6) nx = 6;
        else if (m_st == 5) nx = (m_bus_prev && !bus_rst) ? 0 : 5;
        else if (m_st == 0) nx = (cmd_io_en && cmd_mem_en) ? 1 : 0;
        else if (m_st == 4 && !main_pwr) nx = 5;
        else if (ctl && cfg_be[0]) nx = sw_next(m_st, int'(cfg_wdata[1:0]));
        if (glob_rst) m_pme = 0;
        else if (ctl && cfg_be[1]) m_pme = cfg_wdata[8];
        m_bus_prev = bus_rst;
        m_st = nx;
    endtask

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        logic [1:0] code;
        code = (m_st <= 1) ? 2'b00 : (m_st == 2) ? 2'b01 : (m_st == 3) ? 2'b10 : 2'b11;
        if (a == 6'h01) return 32'h0010_0000 | {30'd0, cmd_mem_en, cmd_io_en};
        if (a == 6'h28) return 32'h0602_0001;
        if (a == 6'h29) return {23'd0, m_pme, 6'd0, code};
        return 32'd0;
    endfunction

    task automatic compare();
        logic [31:0] er;
        bit ei, ep;
        er = exp_rd(cfg_addr);
        ei = (m_st == 1);
        ep = m_pme && (m_st != 0) && (m_st != 6);
        checks += 4;
        if (int'(pm_state) != m_st) begin
            errors++;
            $display("FAIL %s pm_state actual=%0d expected=%0d", tag, pm_state, m_st);
        end
        if (irq_allow !== ei) begin
            errors++;
            $display("FAIL %s irq_allow actual=%0b expected=%0b", tag, irq_allow, ei);
        end
        if (pme_allow !== ep) begin
            errors++;
            $display("FAIL %s pme_allow actual=%0b expected=%0b", tag, pme_allow, ep);
        end
        if (cfg_rdata !== er) begin
            errors++;
            $display("FAIL %s cfg_rdata@%0h actual=%08h expected=%08h", tag, cfg_addr, cfg_rdata, er);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic cfgw(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        step();
        cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; glob_rst = 1'b0; bus_rst = 1'b0;
        main_pwr = 1'b1; aux_pwr = 1'b1; cmd_io_en = 1'b0; cmd_mem_en = 1'b0;
        cfg_wr = 1'b0; cfg_addr = 6'h29; cfg_be = 4'h0; cfg_wdata = 32'h0;
        tag = "R1"; step(2);
        rst_n = 1'b1; step();

        tag = "R11"; cfg_addr = 6'h28; step();
        cfgw(6'h28, 4'hF, 32'hFFFF_FFFF);
        cfg_addr = 6'h28; step();
        cfg_addr = 6'h01; step();

        tag = "R2"; cfg_addr = 6'h29;
        cmd_io_en = 1'b1; step(2);
        cmd_io_en = 1'b0; cmd_mem_en = 1'b1; step(2);
        cmd_io_en = 1'b1; cfgw(6'h29, 4'h1, 32'h1);
        step();

        tag = "R5";
        cfgw(6'h29, 4'h1, 32'h1);
        cfgw(6'h29, 4'h1, 32'h2);
        cfgw(6'h29, 4'h1, 32'h1);
        cfgw(6'h29, 4'h1, 32'h0);
        cfgw(6'h29, 4'h1, 32'h3);
        cfgw(6'h29, 4'h1, 32'h2);

        tag = "R6";
        cfgw(6'h29, 4'h1, 32'h0);
        step();

        tag = "R12";
        cfgw(6'h29, 4'h2, 32'h0000_0103);
        cfgw(6'h29, 4'h1, 32'h0);
        cfg_addr = 6'h3F; step();
        cfg_addr = 6'h29;

        tag = "R3";
        cfgw(6'h29, 4'h1, 32'h1);
        cfgw(6'h29, 4'h1, 32'h2);

        tag = "R7";
        cfgw(6'h29, 4'h1, 32'h3);
        main_pwr = 1'b0; step();
        tag = "R4"; step();

        tag = "R8";
        bus_rst = 1'b1; step(2);
        bus_rst = 1'b0; step();
        main_pwr = 1'b1; step();

        tag = "R9";
        main_pwr = 1'b0; aux_pwr = 1'b0; step();
        main_pwr = 1'b1; aux_pwr = 1'b1; step(2);
        glob_rst = 1'b1; step();
        glob_rst = 1'b0; step();

        tag = "R10";
        cfgw(6'h29, 4'h3, 32'h0000_0102);
        glob_rst = 1'b1;
        cfgw(6'h29, 4'h3, 32'h0000_0103);
        glob_rst = 1'b0; step();

        tag = "R13";
        cfgw(6'h29, 4'h3, 32'h0000_0103);
        main_pwr = 1'b0;
        cfgw(6'h29, 4'h1, 32'h0);
        main_pwr = 1'b1; bus_rst = 1'b1; step();
        bus_rst = 1'b0; step(2);
        main_pwr = 1'b0; aux_pwr = 1'b0;
        cfgw(6'h29, 4'h1, 32'h1);
        main_pwr = 1'b1; aux_pwr = 1'b1;
        glob_rst = 1'b1; step();
        glob_rst = 1'b0; step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule